// File: doc/BRIEF.md
# Hamming-Rate Driven Voltage-Frequency Controller

This block chooses a voltage-frequency operating index for every group of compute macros that share a supply and a clock. A group's index depends on two things: the bit density of the weights loaded into it, and a global operating mode. The bit density is supplied as a 4-bit bin of the fraction of set bits. It does not depend on activations, so it is constant for a task. The index is read from a small programmable table that has one row of 16 bins per mode. A larger index is a more aggressive point (higher frequency and/or lower voltage margin). Mode 1 (sprint) favours frequency and mode 0 (low power) favours voltage.

The index is taken only when a task is accepted, so it stays fixed while the task runs. A droop alarm during a task has three effects. It lowers the index by one at once, it aborts the task, and it raises a recompute request that stays up until it is acknowledged. The next task after a failure runs one index below its table entry. That offset is cleared when that task completes normally. If the group is already at index 0, the alarm sets a sticky error flag instead of stepping further.

Top module: `hrvf_ctrl`

## Requirements
- R1: After reset every group reports index 0, `task_accept` high, `recomp_req` low and `droop_err` low.
- R2: A start on a group with `task_accept` high sets that group's index, one cycle later, to table[mode][bin]. Here mode is `mode_sprint` (1 = sprint, 0 = low power) and bin is the group's 4-bit slice `hr_flat[4g+3:4g]`. The table contents after reset are: sprint entry = 7 - bin/2; low-power entry = (15 - bin)/4, with integer division.
- R3: A write with `tbl_wr_en` high replaces the entry at (`tbl_wr_mode`, `tbl_wr_bin`) with `tbl_wr_val`. The new value is used by every task accepted from the next cycle on.
- R4: While a task runs and no alarm arrives, the group's index does not change, whatever happens to the mode, the bin or the table.
- R5: An alarm on a running group aborts the task. In the next cycle the index is one lower and `recomp_req` is high.
- R6: `recomp_req` stays high until `recomp_ack` is seen. While it is high, `task_accept` is low and starts are ignored.
- R7: The first task accepted after a failure runs at the table entry minus one (floored at 0). Once that task completes with `task_done`, later tasks use the table entry again.
- R8: An alarm on a running group whose index is 0 leaves the index at 0 and sets `droop_err`, which stays set until reset.
- R9: An alarm on a group with no running task has no effect on that group's index or recompute request.
- R10: Each group's start, done, alarm and acknowledge act only on that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sprint | input | 1 | 1 = sprint table, 0 = low-power table |
| hr_flat | input | NGRP*4 | Per-group bit-density bin, group g at bits 4g+3:4g |
| task_start | input | NGRP | Per-group task start request |
| task_done | input | NGRP | Per-group task completion |
| droop_alarm | input | NGRP | Per-group droop-monitor alarm |
| recomp_ack | input | NGRP | Per-group acknowledge of a recompute request |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_mode | input | 1 | Table row selected for the write |
| tbl_wr_bin | input | 4 | Table bin selected for the write |
| tbl_wr_val | input | 3 | Index value written |
| vf_idx | output | NGRP*3 | Per-group operating index, group g at bits 3g+2:3g |
| task_accept | output | NGRP | Group is idle and may take a task |
| recomp_req | output | NGRP | Recompute of the aborted task is requested |
| droop_err | output | NGRP | Sticky: alarm arrived at the lowest index |

## Verification
The assertions assume three things about the inputs. `task_done` and `droop_alarm` are meaningful only while a group runs a task. Starts are pulses that are honoured only while `task_accept` is high. The acknowledge arrives only for a pending request. The stimulus raises each start for a single cycle, and it raises done and alarm only on groups that it has itself put into a running task. It also issues starts against a pending request and alarms on idle groups. Those cases show at the ports that the design ignores them.

// File: rtl/hrvf_pkg.sv
package hrvf_pkg;
  typedef enum logic {
    GRP_IDLE = 1'b0,
    GRP_RUN  = 1'b1
  } grp_state_e;
endpackage

// File: rtl/hrvf_table.sv
module hrvf_table #(
  parameter int NGRP = 4,
  parameter int HRW  = 4,
  parameter int IDXW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_mode,
  input  logic [HRW-1:0]       wr_bin,
  input  logic [IDXW-1:0]      wr_val,
  input  logic                 rd_mode,
  input  logic [NGRP*HRW-1:0]  rd_bins,
  output logic [NGRP*IDXW-1:0] rd_idx
);
  localparam int NBIN = 1 << HRW;
  localparam int NIDX = 1 << IDXW;

  // Reset contents: sprint falls from the top index, low power from half of it
  function automatic logic [IDXW-1:0] reset_entry(input int m, input int b);
    int v;
    if (m == 1) v = (NIDX - 1) - (b * NIDX) / NBIN;
    else        v = ((NBIN - 1 - b) * NIDX) / (2 * NBIN);
    return IDXW'(v);
  endfunction

  logic [IDXW-1:0] ent_q [2][NBIN];
  logic [IDXW-1:0] ent_d [2][NBIN];

  always_comb begin
    for (int m = 0; m < 2; m++)
      for (int b = 0; b < NBIN; b++)
        ent_d[m][b] = ent_q[m][b];
    if (wr_en) ent_d[wr_mode][wr_bin] = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < 2; m++)
        for (int b = 0; b < NBIN; b++)
          ent_q[m][b] <= reset_entry(m, b);
    end else if (wr_en) begin
      for (int m = 0; m < 2; m++)
        for (int b = 0; b < NBIN; b++)
          ent_q[m][b] <= ent_d[m][b];
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_rd
    assign rd_idx[g*IDXW +: IDXW] = ent_q[rd_mode][rd_bins[g*HRW +: HRW]];
  end
endmodule

// File: rtl/hrvf_group.sv
module hrvf_group
  import hrvf_pkg::*;
#(
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            done,
  input  logic            alarm,
  input  logic            ack,
  input  logic [IDXW-1:0] tbl_idx,
  output logic [IDXW-1:0] vf_idx,
  output logic            accept,
  output logic            rc_req,
  output logic            err,
  output logic            busy
);
  localparam logic [IDXW-1:0] ONE  = IDXW'(1);
  localparam logic [IDXW-1:0] ZERO = '0;

  grp_state_e      st_q, st_d;
  logic [IDXW-1:0] vf_q, vf_d;
  logic            safe_q, safe_d;
  logic            pend_q, pend_d;
  logic            err_q, err_d;
  logic            upd;
  logic [IDXW-1:0] launch_idx;

  assign accept     = (st_q == GRP_IDLE) && !pend_q;
  assign launch_idx = !safe_q ? tbl_idx : ((tbl_idx == ZERO) ? ZERO : tbl_idx - ONE);

  always_comb begin
    st_d   = st_q;
    vf_d   = vf_q;
    safe_d = safe_q;
    pend_d = pend_q;
    err_d  = err_q;
    unique case (st_q)
      GRP_IDLE: begin
        if (pend_q && ack) pend_d = 1'b0;
        if (accept && start) begin
          st_d = GRP_RUN;
          vf_d = launch_idx;
        end
      end
      GRP_RUN: begin
        if (alarm) begin
          st_d   = GRP_IDLE;
          pend_d = 1'b1;
          safe_d = 1'b1;
          if (vf_q == ZERO) err_d = 1'b1;
          else              vf_d  = vf_q - ONE;
        end else if (done) begin
          st_d   = GRP_IDLE;
          safe_d = 1'b0;
        end
      end
      default: st_d = GRP_IDLE;
    endcase
  end

  assign upd = (st_q == GRP_RUN) ? (alarm || done) : ((pend_q && ack) || (accept && start));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= GRP_IDLE;
      vf_q   <= ZERO;
      safe_q <= 1'b0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (upd) begin
      st_q   <= st_d;
      vf_q   <= vf_d;
      safe_q <= safe_d;
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  assign vf_idx = vf_q;
  assign rc_req = pend_q;
  assign err    = err_q;
  assign busy   = (st_q == GRP_RUN);
endmodule

// File: rtl/hrvf_ctrl.sv
module hrvf_ctrl #(
  parameter int NGRP = 4,
  parameter int HRW  = 4,
  parameter int IDXW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_sprint,
  input  logic [NGRP*HRW-1:0]  hr_flat,
  input  logic [NGRP-1:0]      task_start,
  input  logic [NGRP-1:0]      task_done,
  input  logic [NGRP-1:0]      droop_alarm,
  input  logic [NGRP-1:0]      recomp_ack,
  input  logic                 tbl_wr_en,
  input  logic                 tbl_wr_mode,
  input  logic [HRW-1:0]       tbl_wr_bin,
  input  logic [IDXW-1:0]      tbl_wr_val,
  output logic [NGRP*IDXW-1:0] vf_idx,
  output logic [NGRP-1:0]      task_accept,
  output logic [NGRP-1:0]      recomp_req,
  output logic [NGRP-1:0]      droop_err
);
  logic [1:0]           rsync_q;
  logic                 rst_sync_n;
  logic [NGRP*IDXW-1:0] tbl_rd;
  logic [NGRP-1:0]      busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  hrvf_table #(.NGRP(NGRP), .HRW(HRW), .IDXW(IDXW)) u_table (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (tbl_wr_en),
    .wr_mode (tbl_wr_mode),
    .wr_bin  (tbl_wr_bin),
    .wr_val  (tbl_wr_val),
    .rd_mode (mode_sprint),
    .rd_bins (hr_flat),
    .rd_idx  (tbl_rd)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    hrvf_group #(.IDXW(IDXW)) u_grp (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .start   (task_start[g]),
      .done    (task_done[g]),
      .alarm   (droop_alarm[g]),
      .ack     (recomp_ack[g]),
      .tbl_idx (tbl_rd[g*IDXW +: IDXW]),
      .vf_idx  (vf_idx[g*IDXW +: IDXW]),
      .accept  (task_accept[g]),
      .rc_req  (recomp_req[g]),
      .err     (droop_err[g]),
      .busy    (busy[g])
    );
  end
endmodule

// File: rtl/hrvf_chk.sv
module hrvf_chk #(
  parameter int NGRP = 4,
  parameter int IDXW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NGRP-1:0]      busy,
  input logic [NGRP-1:0]      droop_alarm,
  input logic [NGRP-1:0]      recomp_ack,
  input logic [NGRP*IDXW-1:0] vf_idx,
  input logic [NGRP-1:0]      task_accept,
  input logic [NGRP-1:0]      recomp_req,
  input logic [NGRP-1:0]      droop_err
);
  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    // R4
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[g] && !droop_alarm[g]) |=> $stable(vf_idx[g*IDXW +: IDXW]));
    // R5
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[g] && droop_alarm[g] && vf_idx[g*IDXW +: IDXW] != '0) |=>
      (vf_idx[g*IDXW +: IDXW] == $past(vf_idx[g*IDXW +: IDXW]) - IDXW'(1)));
    // R5
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[g] && droop_alarm[g]) |=> (!busy[g] && recomp_req[g]));
    // R6
    pend_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      recomp_req[g] |-> !task_accept[g]);
    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (recomp_req[g] && !recomp_ack[g]) |=> recomp_req[g]);
    // R8
    floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[g] && droop_alarm[g] && vf_idx[g*IDXW +: IDXW] == '0) |=>
      (droop_err[g] && vf_idx[g*IDXW +: IDXW] == '0));
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      droop_err[g] |=> droop_err[g]);
    // R9
    idle_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy[g] && !recomp_req[g]) |=> !recomp_req[g]);
  end
endmodule

bind hrvf_ctrl hrvf_chk #(.NGRP(NGRP), .IDXW(IDXW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .busy        (busy),
  .droop_alarm (droop_alarm),
  .recomp_ack  (recomp_ack),
  .vf_idx      (vf_idx),
  .task_accept (task_accept),
  .recomp_req  (recomp_req),
  .droop_err   (droop_err)
);

// File: tb/test_hrvf_ctrl.sv
`timescale 1ns/1ps
module test_hrvf_ctrl;
  localparam int NG = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_sprint;
  logic [NG*4-1:0] hr_flat;
  logic [NG-1:0] task_start, task_done, droop_alarm, recomp_ack;
  logic          tbl_wr_en, tbl_wr_mode;
  logic [3:0]    tbl_wr_bin;
  logic [2:0]    tbl_wr_val;
  logic [NG*3-1:0] vf_idx;
  logic [NG-1:0] task_accept, recomp_req, droop_err;

  int errors = 0;
  int checks = 0;
  int exp_tbl [2][16];

  always #2 clk = ~clk;

  hrvf_ctrl #(.NGRP(NG), .HRW(4), .IDXW(3)) i_hrvf_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_sprint(mode_sprint), .hr_flat(hr_flat),
    .task_start(task_start), .task_done(task_done), .droop_alarm(droop_alarm),
    .recomp_ack(recomp_ack), .tbl_wr_en(tbl_wr_en), .tbl_wr_mode(tbl_wr_mode),
    .tbl_wr_bin(tbl_wr_bin), .tbl_wr_val(tbl_wr_val), .vf_idx(vf_idx),
    .task_accept(task_accept), .recomp_req(recomp_req), .droop_err(droop_err)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int vf(input int g);
    return int'(vf_idx[g*3 +: 3]);
  endfunction

  task automatic start_task(input int g, input int b);
    hr_flat[g*4 +: 4] = 4'(b);
    task_start[g] = 1'b1;
    tick();
    task_start[g] = 1'b0;
  endtask

  task automatic end_task(input int g);
    task_done[g] = 1'b1;
    tick();
    task_done[g] = 1'b0;
  endtask

  task automatic fire_alarm(input int g);
    droop_alarm[g] = 1'b1;
    tick();
    droop_alarm[g] = 1'b0;
  endtask

  task automatic ack(input int g);
    recomp_ack[g] = 1'b1;
    tick();
    recomp_ack[g] = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int m = 0; m < 2; m++) begin
      mode_sprint = m[0];
      for (int b = 0; b < 16; b++) begin
        for (int g = 0; g < NG; g++) begin
          start_task(g, b);
          check(vf(g) == exp_tbl[m][b], tag, vf(g), exp_tbl[m][b]);
          end_task(g);
        end
      end
    end
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hold;
    rst_n = 1'b0; mode_sprint = 1'b0; hr_flat = '0;
    task_start = '0; task_done = '0; droop_alarm = '0; recomp_ack = '0;
    tbl_wr_en = 1'b0; tbl_wr_mode = 1'b0; tbl_wr_bin = '0; tbl_wr_val = '0;
    for (int b = 0; b < 16; b++) begin
      exp_tbl[1][b] = 7 - b / 2;
      exp_tbl[0][b] = (15 - b) / 4;
    end
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    for (int g = 0; g < NG; g++) begin
      check(vf(g) == 0, "R1 index", vf(g), 0);
      check(task_accept[g] == 1'b1, "R1 accept", int'(task_accept[g]), 1);
      check(recomp_req[g] == 1'b0, "R1 recompute", int'(recomp_req[g]), 0);
      check(droop_err[g] == 1'b0, "R1 error", int'(droop_err[g]), 0);
    end

    // R2 reset table, every mode, bin and group
    sweep("R2 table lookup");

    // R3 reprogram whole table, then sweep again
    for (int m = 0; m < 2; m++)
      for (int b = 0; b < 16; b++) begin
        exp_tbl[m][b] = (b * 3 + m * 5) % 8;
        tbl_wr_en = 1'b1; tbl_wr_mode = m[0]; tbl_wr_bin = 4'(b);
        tbl_wr_val = 3'(exp_tbl[m][b]);
        tick();
      end
    tbl_wr_en = 1'b0;
    sweep("R3 programmed lookup");

    // R4 index held while running despite mode, bin and table changes
    mode_sprint = 1'b1;
    start_task(2, 1);                    // exp 8%8 = 0 -> use bin 2 instead below
    end_task(2);
    start_task(2, 2);                    // sprint bin 2: (6+5)%8 = 3
    hold = vf(2);
    check(hold == exp_tbl[1][2], "R4 start", hold, exp_tbl[1][2]);
    mode_sprint = 1'b0; hr_flat[8 +: 4] = 4'd9;
    tbl_wr_en = 1'b1; tbl_wr_mode = 1'b1; tbl_wr_bin = 4'd2; tbl_wr_val = 3'd7;
    tick();
    tbl_wr_en = 1'b0; exp_tbl[1][2] = 7;
    repeat (3) tick();
    check(vf(2) == hold, "R4 hold", vf(2), hold);
    end_task(2);
    check(vf(2) == hold, "R4 after done", vf(2), hold);

    // R5/R6/R7 failure path on group 1 (sprint bin 2 now 7)
    mode_sprint = 1'b1;
    hold = vf(0);
    start_task(1, 2);
    check(vf(1) == 7, "R5 pre-failure", vf(1), 7);
    fire_alarm(1);
    check(vf(1) == 6, "R5 step down", vf(1), 6);
    check(recomp_req[1] == 1'b1, "R5 recompute raised", int'(recomp_req[1]), 1);
    check(task_accept[1] == 1'b0, "R6 accept blocked", int'(task_accept[1]), 0);
    start_task(1, 2);
    check(vf(1) == 6, "R6 start ignored index", vf(1), 6);
    check(recomp_req[1] == 1'b1, "R6 request held", int'(recomp_req[1]), 1);
    check(vf(0) == hold, "R10 neighbour index", vf(0), hold);
    check(recomp_req[0] == 1'b0, "R10 neighbour request", int'(recomp_req[0]), 0);
    ack(1);
    check(recomp_req[1] == 1'b0, "R6 request cleared", int'(recomp_req[1]), 0);
    check(task_accept[1] == 1'b1, "R6 accept restored", int'(task_accept[1]), 1);
    start_task(1, 2);
    check(vf(1) == 6, "R7 safe offset", vf(1), 6);
    fire_alarm(1);                       // second failure during recompute
    check(vf(1) == 5, "R5 second step", vf(1), 5);
    ack(1);
    start_task(1, 2);
    check(vf(1) == 6, "R7 offset still one", vf(1), 6);
    end_task(1);
    start_task(1, 2);
    check(vf(1) == 7, "R7 offset cleared", vf(1), 7);
    end_task(1);

    // R8 alarm at index 0 (low power bin 0 = 0)
    tbl_wr_en = 1'b1; tbl_wr_mode = 1'b0; tbl_wr_bin = 4'd0; tbl_wr_val = 3'd0;
    tick();
    tbl_wr_en = 1'b0; exp_tbl[0][0] = 0;
    mode_sprint = 1'b0;
    start_task(3, 0);
    check(vf(3) == 0, "R8 at floor", vf(3), 0);
    fire_alarm(3);
    check(vf(3) == 0, "R8 floor held", vf(3), 0);
    check(droop_err[3] == 1'b1, "R8 error set", int'(droop_err[3]), 1);
    check(droop_err[2] == 1'b0, "R10 error isolated", int'(droop_err[2]), 0);
    ack(3);
    start_task(3, 0);
    end_task(3);
    repeat (2) tick();
    check(droop_err[3] == 1'b1, "R8 error sticky", int'(droop_err[3]), 1);

    // R9 alarm on an idle group
    hold = vf(0);
    fire_alarm(0);
    check(vf(0) == hold, "R9 idle index", vf(0), hold);
    check(recomp_req[0] == 1'b0, "R9 idle request", int'(recomp_req[0]), 0);
    check(task_accept[0] == 1'b1, "R9 idle accept", int'(task_accept[0]), 1);
    check(droop_err[0] == 1'b0, "R9 idle error", int'(droop_err[0]), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule